// File: doc/BRIEF.md
# User Mode Entry Fuse Counter

This block decides when a paged 8-bit CPU leaves system mode and enters a user context. Software writes one byte to a write-only selection register. The upper nibble of that byte is a fuse count and the lower nibble is a user number. After the write, the block counts qualified E-clock strobes. When the count expires, the stored user number becomes the active bank index and the mode flag switches. The bank index drives the high address bits of the translation table.

The delay exists so that the return-from-interrupt sequence can be timed. System code writes the register just before the return instruction. It chooses the count so that the switch happens partway through the stack pull, which means the restored registers come from the user page. Hardware forces the way back out: an interrupt-acknowledge cycle immediately returns the CPU to system mode, clears the pending user number and enables the translation table.

The block runs on the system clock and advances once for each single-cycle E strobe. Reset is synchronous and active high.

Top module: `fuse_mode_switch`

## Requirements
- R1: While reset is high and on the first cycle after it, `user_mode` is 0, `bank_idx` is 0 and `dat_en` is 0.
- R2: A write (`wr_en` high, `iack` low) with count N in `wr_data[7:4]` leaves the outputs unchanged through the next N E strobes. The outputs change at the clock edge that samples the (N+1)th strobe after the write.
- R3: At expiry, `bank_idx` takes the user number that was written in `wr_data[3:0]`.
- R4: At expiry, `user_mode` becomes 1 if the user number is nonzero and 0 if it is zero. `user_mode` is never 1 while `bank_idx` is 0.
- R5: A count of 0 applies the user number at the first E strobe after the write.
- R6: Clock cycles in which `e_stb` is low do not advance the countdown, and they never change `bank_idx` or `user_mode`.
- R7: A write made while a countdown is pending replaces both the count and the user number, and the countdown restarts from the new count.
- R8: An `iack` cycle sets `user_mode` to 0, `bank_idx` to 0 and `dat_en` to 1 on the next cycle. It also cancels any pending countdown, so later strobes do not switch the mode.
- R9: A write in the same cycle as `iack` is ignored.
- R10: A write whose user number is 0 sets `dat_en` to 1. A write with a nonzero user number leaves `dat_en` unchanged. Once `dat_en` is set, it stays at 1 until reset.
- R11: An E strobe in the same cycle as a write is not counted against the new count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| e_stb | input | 1 | One-cycle strobe, one per CPU E-clock cycle |
| wr_en | input | 1 | Write strobe for the selection register (already address-decoded) |
| wr_data | input | 8 | Bits 7:4 are the fuse count, bits 3:0 are the user number |
| iack | input | 1 | Interrupt-acknowledge bus cycle indication, one clock long |
| bank_idx | output | 4 | Active bank index for the translation table high address bits |
| user_mode | output | 1 | 1 = user mode, 0 = system mode |
| dat_en | output | 1 | Translation table enabled |

## Verification
The assertions assume the following about the inputs:
- `e_stb`, `wr_en` and `iack` are synchronous to `clk`.
- Each of them is a single-clock pulse per event.
- `iack` may coincide with a write or a strobe, and the block resolves that case by priority.

The stimulus drives every input on the falling edge and holds each pulse for exactly one rising edge. Idle cycles are placed between strobes so that a missed qualification would show up as an early switch. Coincident write, strobe and `iack` cycles are produced only in the directed cases that target those priorities.

// File: rtl/fuse_pkg.sv
package fuse_pkg;

    localparam int CNT_W  = 4;
    localparam int USER_W = 4;
    localparam int DATA_W = CNT_W + USER_W;

    typedef struct packed {
        logic [CNT_W-1:0]  count;
        logic [USER_W-1:0] user;
    } sel_word_t;

    typedef enum logic {
        MODE_SYS  = 1'b0,
        MODE_USER = 1'b1
    } cpu_mode_e;

    typedef struct packed {
        logic      load;
        logic      clear;
        sel_word_t word;
    } fuse_cmd_t;

    function automatic sel_word_t split_word(logic [DATA_W-1:0] d);
        sel_word_t w;
        w.count = d[DATA_W-1:USER_W];
        w.user  = d[USER_W-1:0];
        return w;
    endfunction

    function automatic cpu_mode_e mode_for(logic [USER_W-1:0] u);
        return (u != '0) ? MODE_USER : MODE_SYS;
    endfunction

endpackage

// File: rtl/fuse_cmd_decode.sv
module fuse_cmd_decode
    import fuse_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          wr_en,
    input  logic          iack,
    input  logic [DW-1:0] wr_data,
    output fuse_cmd_t     cmd
);
    // Interrupt acknowledge outranks a register write in the same cycle.
    always_comb begin
        cmd.clear = iack;
        cmd.load  = wr_en & ~iack;
        cmd.word  = split_word(wr_data);
    end
endmodule

// File: rtl/fuse_countdown.sv
module fuse_countdown #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          clear,
    input  logic          e_stb,
    input  logic [CW-1:0] load_cnt,
    output logic          expire
);
    logic [CW-1:0] cnt_q;
    logic          run_q;
    logic          at_zero;

    assign at_zero = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (load) begin
            run_q <= 1'b1;
            cnt_q <= load_cnt;
        end else if (run_q && e_stb) begin
            if (at_zero) begin
                run_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign expire = run_q & e_stb & at_zero & ~load & ~clear;
endmodule

// File: rtl/fuse_mode_ctl.sv
module fuse_mode_ctl
    import fuse_pkg::*;
#(
    parameter int UW = USER_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          load,
    input  logic [UW-1:0] load_user,
    input  logic          expire,
    output logic [UW-1:0] bank_q,
    output cpu_mode_e     mode_q,
    output logic          dat_en_q
);
    logic [UW-1:0] pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q   <= '0;
            bank_q   <= '0;
            mode_q   <= MODE_SYS;
            dat_en_q <= 1'b0;
        end else if (clear) begin
            pend_q   <= '0;
            bank_q   <= '0;
            mode_q   <= MODE_SYS;
            dat_en_q <= 1'b1;
        end else begin
            if (load) begin
                pend_q <= load_user;
                if (load_user == '0) begin
                    dat_en_q <= 1'b1;
                end
            end
            if (expire) begin
                bank_q <= pend_q;
                mode_q <= mode_for(pend_q);
            end
        end
    end
endmodule

// File: rtl/fuse_mode_switch.sv
module fuse_mode_switch
    import fuse_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              e_stb,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              iack,
    output logic [USER_W-1:0] bank_idx,
    output logic              user_mode,
    output logic              dat_en
);
    fuse_cmd_t cmd;
    logic      expire;
    cpu_mode_e mode;

    fuse_cmd_decode #(.DW(DATA_W)) u_dec (
        .wr_en   (wr_en),
        .iack    (iack),
        .wr_data (wr_data),
        .cmd     (cmd)
    );

    fuse_countdown #(.CW(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (cmd.load),
        .clear    (cmd.clear),
        .e_stb    (e_stb),
        .load_cnt (cmd.word.count),
        .expire   (expire)
    );

    fuse_mode_ctl #(.UW(USER_W)) u_ctl (
        .clk       (clk),
        .rst       (rst),
        .clear     (cmd.clear),
        .load      (cmd.load),
        .load_user (cmd.word.user),
        .expire    (expire),
        .bank_q    (bank_idx),
        .mode_q    (mode),
        .dat_en_q  (dat_en)
    );

    assign user_mode = (mode == MODE_USER);
endmodule

// File: rtl/fuse_mode_switch_chk.sv
module fuse_mode_switch_chk
    import fuse_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              e_stb,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic              iack,
    input logic [USER_W-1:0] bank_idx,
    input logic              user_mode,
    input logic              dat_en
);
    p_reset_r1: assert property (@(posedge clk)
        rst |=> (!user_mode && bank_idx == '0 && !dat_en));

    p_iack_r8: assert property (@(posedge clk) disable iff (rst)
        iack |=> (!user_mode && bank_idx == '0 && dat_en));

    p_user_bank_r4: assert property (@(posedge clk) disable iff (rst)
        user_mode |-> (bank_idx != '0));

    p_no_strobe_r6: assert property (@(posedge clk) disable iff (rst)
        (!e_stb && !iack) |=> ($stable(bank_idx) && $stable(user_mode)));

    p_zero_user_r10: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !iack && wr_data[USER_W-1:0] == '0) |=> dat_en);

    p_dat_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        dat_en |=> dat_en);

    p_write_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !iack) |=> ($stable(bank_idx) && $stable(user_mode)));
endmodule

bind fuse_mode_switch fuse_mode_switch_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .e_stb     (e_stb),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .iack      (iack),
    .bank_idx  (bank_idx),
    .user_mode (user_mode),
    .dat_en    (dat_en)
);

// File: tb/tb_fuse_mode_switch.sv
module tb_fuse_mode_switch;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       e_stb = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       iack = 1'b0;
    logic [3:0] bank_idx;
    logic       user_mode;
    logic       dat_en;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    fuse_mode_switch dut (
        .clk(clk), .rst(rst), .e_stb(e_stb), .wr_en(wr_en),
        .wr_data(wr_data), .iack(iack),
        .bank_idx(bank_idx), .user_mode(user_mode), .dat_en(dat_en)
    );

    localparam int NVEC = 6;
    localparam logic [7:0] VEC [NVEC] = '{8'h35, 8'h07, 8'h1A, 8'hF3, 8'h20, 8'h5F};

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic write(input logic [7:0] d, input logic with_stb);
        wr_en = 1'b1; wr_data = d; e_stb = with_stb;
        tick();
        wr_en = 1'b0; e_stb = 1'b0;
    endtask

    task automatic strobe();
        tick();
        e_stb = 1'b1;
        tick();
        e_stb = 1'b0;
    endtask

    task automatic do_iack();
        iack = 1'b1;
        tick();
        iack = 1'b0;
    endtask

    function automatic logic [7:0] state5();
        return {3'b000, user_mode, bank_idx};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        tick(); tick();
        check("R1 reset during", {2'b0, dat_en, user_mode, bank_idx}, 8'h00);
        rst = 1'b0;
        tick();
        check("R1 reset after", {2'b0, dat_en, user_mode, bank_idx}, 8'h00);

        // R10: nonzero user leaves dat_en low; zero user sets it
        write(8'h35, 1'b0);
        check("R10 nonzero write dat_en", {7'b0, dat_en}, 8'h00);
        do_iack();
        rst = 1'b1; tick(); rst = 1'b0; tick();
        write(8'h00, 1'b0);
        check("R10 zero write dat_en", {7'b0, dat_en}, 8'h01);

        // R2 R3 R4 R5: table walk
        for (int i = 0; i < NVEC; i++) begin
            do_iack();
            write(VEC[i], 1'b0);
            for (int k = 0; k < int'(VEC[i][7:4]); k++) begin
                strobe();
            end
            check("R2 before expiry", state5(), 8'h00);
            strobe();
            check("R3 R4 R5 at expiry", state5(),
                  {3'b000, (VEC[i][3:0] != 4'h0), VEC[i][3:0]});
        end

        // R6: idle cycles do not count
        do_iack();
        write(8'h04, 1'b0);
        repeat (10) tick();
        check("R6 idle no change", state5(), 8'h00);
        strobe();
        check("R6 switch after strobe", state5(), 8'h14);

        // R7: reload restarts countdown
        do_iack();
        write(8'h34, 1'b0);
        strobe(); strobe();
        write(8'h26, 1'b0);
        strobe(); strobe();
        check("R7 reloaded still pending", state5(), 8'h00);
        strobe();
        check("R7 new user applied", state5(), 8'h16);

        // R8: iack from user mode, and cancel of pending
        do_iack();
        check("R8 iack to system", {2'b0, dat_en, user_mode, bank_idx}, 8'h20);
        write(8'h28, 1'b0);
        strobe();
        do_iack();
        repeat (5) strobe();
        check("R8 pending cancelled", state5(), 8'h00);

        // R9: write during iack ignored
        iack = 1'b1; wr_en = 1'b1; wr_data = 8'h03;
        tick();
        iack = 1'b0; wr_en = 1'b0;
        strobe(); strobe();
        check("R9 write with iack ignored", state5(), 8'h00);

        // R11: strobe during write not counted
        write(8'h19, 1'b1);
        strobe();
        check("R11 coincident strobe not counted", state5(), 8'h00);
        strobe();
        check("R11 switch on second strobe", state5(), 8'h19);

        // R10: dat_en stays set across later writes
        write(8'h0C, 1'b0);
        check("R10 dat_en sticky", {7'b0, dat_en}, 8'h01);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule